// File: doc/BRIEF.md
# Cascadable synchronous up/down counter

This block is a binary counter built from a chain of identical stages, each `STAGE_W` bits wide (four by default), joined into one count of `STAGE_W*STAGES` bits. On every rising clock edge it can take a preset value, step by one in either direction, or keep its value. Every stage wraps modulo 2^`STAGE_W`, so the combined count wraps from all ones to zero going up and from zero to all ones going down.

All controls are active-low except the direction select. The load takes priority over counting. Each stage has two count enables. The per-stage parallel enable holds only that stage. The trickle enable passes along the chain. Each stage drives an active-low terminal-count flag that feeds the trickle enable of the next stage. That flag is a combinational decode of the stage value, the direction and the stage's trickle enable. It does not depend on the parallel enable, so carries and borrows look ahead through the chain within the same cycle. The flag of the last stage is the block's terminal-count output. It must not be used as a clock.

An active-low asynchronous reset clears the count so that simulation starts from a known state.

Top module: `updn_cascade`

## Requirements
- R1: While `rst_n` is low the count is 0, whatever the other inputs do. With `up`=1 and `trk_en_n`=0 at zero, `tc_n` reads 1.
- R2: A rising edge with `load_n`=0 copies `preset` into `count`. This happens whatever the values of `par_en_n`, `trk_en_n` and `up`.
- R3: With `load_n`=1, `trk_en_n`=0, all bits of `par_en_n` at 0 and `up`=1, each edge adds 1 to `count`. The count wraps from all ones (255 at default size) to 0.
- R4: With `load_n`=1, `trk_en_n`=0, all bits of `par_en_n` at 0 and `up`=0, each edge subtracts 1 from `count`. The count wraps from 0 to all ones.
- R5: Stage i occupies bits [i*STAGE_W +: STAGE_W]. Its trickle enable is `trk_en_n` for stage 0 and the previous stage's terminal flag for later stages. With `load_n`=1, `par_en_n[i]`=1 holds stage i. With `par_en_n[i]`=0 and a low trickle enable, stage i steps in the direction set by `up`.
- R6: With `load_n`=1 and `trk_en_n`=1 the whole count holds.
- R7: `tc_n` is 0 exactly when `trk_en_n`=0 and the whole count is all ones with `up`=1, or all zeros with `up`=0. In every other case it is 1. It does not depend on `par_en_n`.
- R8: `tc_n` follows changes of `up`, `trk_en_n` and `count` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, clears the count |
| load_n | input | 1 | Preset load, active low, highest priority |
| par_en_n | input | STAGES | Per-stage parallel count enable, active low |
| trk_en_n | input | 1 | Trickle count enable into stage 0, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| preset | input | STAGE_W*STAGES | Value taken on a load |
| count | output | STAGE_W*STAGES | Current count |
| tc_n | output | 1 | Terminal count of the last stage, active low |

## Verification
Loads, steps and holds show on `count` exactly one rising edge after the inputs are applied. The bench therefore drives inputs 2 ns after an edge and compares `count` 2 ns after the following edge, against a value computed from the previous expected value and the applied inputs. `tc_n` is combinational, so it is compared in the same sampling window against the just-updated expected count and the current `up` and `trk_en_n`. For R8 it is also compared 1 ns after `up` or `trk_en_n` changes, with no edge in between. A sweep loads every 8-bit value and then applies each of the 16 combinations of enables and direction for one edge.

// File: rtl/updn_pkg.sv
package updn_pkg;

    // Action a stage takes on the next rising edge
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_LOAD = 2'd1,
        STEP_INC  = 2'd2,
        STEP_DEC  = 2'd3
    } step_e;

    // Load wins; either enable high holds; otherwise direction picks
    function automatic step_e pick_step(input logic load_n,
                                        input logic cep_n,
                                        input logic cet_n,
                                        input logic up);
        if (!load_n)
            return STEP_LOAD;
        if (cep_n || cet_n)
            return STEP_HOLD;
        return up ? STEP_INC : STEP_DEC;
    endfunction

endpackage

// File: rtl/updn_term_decode.sv
module updn_term_decode #(
    parameter int W = 4
) (
    input  logic [W-1:0] value,
    input  logic         up,
    input  logic         cet_n,
    output logic         tc_n
);

    logic at_top;
    logic at_bottom;
    logic at_end;

    always_comb begin
        at_top    = &value;
        at_bottom = ~|value;
        at_end    = up ? at_top : at_bottom;
        tc_n      = !(!cet_n && at_end);
    end

endmodule

// File: rtl/updn_stage.sv
module updn_stage
    import updn_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_n,
    input  logic         cep_n,
    input  logic         cet_n,
    input  logic         up,
    input  logic [W-1:0] preset,
    output logic [W-1:0] count,
    output logic         tc_n
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t s_d;
    stage_t s_q;
    step_e  step;

    always_comb begin
        s_d  = s_q;
        step = pick_step(load_n, cep_n, cet_n, up);
        unique case (step)
            STEP_LOAD: s_d.cnt = preset;
            STEP_INC:  s_d.cnt = s_q.cnt + 1'b1;
            STEP_DEC:  s_d.cnt = s_q.cnt - 1'b1;
            default:   s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign count = s_q.cnt;

    updn_term_decode #(.W(W)) u_term (
        .value (s_q.cnt),
        .up    (up),
        .cet_n (cet_n),
        .tc_n  (tc_n)
    );

endmodule

// File: rtl/updn_cascade.sv
module updn_cascade #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2,
    localparam int TOTAL_W = STAGE_W * STAGES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_n,
    input  logic [STAGES-1:0]  par_en_n,
    input  logic               trk_en_n,
    input  logic               up,
    input  logic [TOTAL_W-1:0] preset,
    output logic [TOTAL_W-1:0] count,
    output logic               tc_n
);

    // chain_n[i] is the trickle enable of stage i; chain_n[STAGES] is the last flag
    logic [STAGES:0] chain_n;

    assign chain_n[0] = trk_en_n;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        updn_stage #(.W(STAGE_W)) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_n (load_n),
            .cep_n  (par_en_n[g]),
            .cet_n  (chain_n[g]),
            .up     (up),
            .preset (preset[g*STAGE_W +: STAGE_W]),
            .count  (count[g*STAGE_W +: STAGE_W]),
            .tc_n   (chain_n[g+1])
        );
    end

    assign tc_n = chain_n[STAGES];

endmodule

// File: rtl/updn_cascade_chk.sv
module updn_cascade_chk #(
    parameter int STAGE_W = 4,
    parameter int STAGES  = 2,
    localparam int TOTAL_W = STAGE_W * STAGES
) (
    input logic               clk,
    input logic               rst_n,
    input logic               load_n,
    input logic [STAGES-1:0]  par_en_n,
    input logic               trk_en_n,
    input logic               up,
    input logic [TOTAL_W-1:0] preset,
    input logic [TOTAL_W-1:0] count,
    input logic               tc_n
);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_CLEAR: assert (count == '0); // R1
        end
    end

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> count == $past(preset)); // R2

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !trk_en_n && par_en_n == '0 && up)
        |=> count == TOTAL_W'($past(count) + 1'b1)); // R3

    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !trk_en_n && par_en_n == '0 && !up)
        |=> count == TOTAL_W'($past(count) - 1'b1)); // R4

    AST_STAGE0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && par_en_n[0]) |=> $stable(count[STAGE_W-1:0])); // R5

    AST_TRK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && trk_en_n) |=> $stable(count)); // R6

    AST_TC_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        tc_n == !(!trk_en_n && (up ? (count == '1) : (count == '0)))); // R7

endmodule

bind updn_cascade updn_cascade_chk #(
    .STAGE_W (STAGE_W),
    .STAGES  (STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_n   (load_n),
    .par_en_n (par_en_n),
    .trk_en_n (trk_en_n),
    .up       (up),
    .preset   (preset),
    .count    (count),
    .tc_n     (tc_n)
);

// File: tb/updn_cascade_bench.sv
`timescale 1ns/1ps
module updn_cascade_bench;

    localparam int SW = 4;
    localparam int NS = 2;
    localparam int TW = SW * NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          load_n = 1'b1;
    logic [NS-1:0] par_en_n = '0;
    logic          trk_en_n = 1'b0;
    logic          up = 1'b1;
    logic [TW-1:0] preset = '0;
    logic [TW-1:0] count;
    logic          tc_n;

    int checks = 0;
    int errors = 0;
    logic [TW-1:0] exp_cnt = '0;

    always #4 clk = ~clk;

    updn_cascade #(.STAGE_W(SW), .STAGES(NS)) u_updn_cascade (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .par_en_n (par_en_n),
        .trk_en_n (trk_en_n),
        .up       (up),
        .preset   (preset),
        .count    (count),
        .tc_n     (tc_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Expected terminal flag from the whole count (R7)
    function automatic logic tc_of(input logic [TW-1:0] c, input logic trk, input logic u);
        if (trk) return 1'b1;
        if (u) return (c == {TW{1'b1}}) ? 1'b0 : 1'b1;
        return (c == '0) ? 1'b0 : 1'b1;
    endfunction

    // Next value from R2..R6, stage by stage
    function automatic logic [TW-1:0] nxt(input logic [TW-1:0] c, input logic ld,
                                          input logic [NS-1:0] par, input logic trk,
                                          input logic u, input logic [TW-1:0] pre);
        logic [TW-1:0] r = c;
        logic cet = trk;
        int nib;
        for (int s = 0; s < NS; s++) begin
            nib = int'(c[s*SW +: SW]);
            if (!ld)
                r[s*SW +: SW] = pre[s*SW +: SW];
            else if (!par[s] && !cet)
                r[s*SW +: SW] = SW'(u ? nib + 1 : nib + 15);
            if (!(!cet && (u ? nib == 15 : nib == 0)))
                cet = 1'b1;
            else
                cet = 1'b0;
        end
        return r;
    endfunction

    // Apply inputs mid-cycle, clock once, compare 2 ns after the edge
    task automatic cyc(input logic ld, input logic [NS-1:0] par, input logic trk,
                       input logic u, input logic [TW-1:0] pre, input string tag);
        load_n = ld; par_en_n = par; trk_en_n = trk; up = u; preset = pre;
        exp_cnt = nxt(exp_cnt, ld, par, trk, u, pre);
        @(posedge clk);
        #2;
        chk(count == exp_cnt, tag, int'(count), int'(exp_cnt));
        chk(tc_n == tc_of(exp_cnt, trk, u), "R7", int'(tc_n), int'(tc_of(exp_cnt, trk, u)));
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tag;
        #1 rst_n = 1'b0;
        #2;
        chk(count == '0, "R1", int'(count), 0);
        chk(tc_n == 1'b1, "R1", int'(tc_n), 1);
        // enables active during reset: still zero
        repeat (3) @(posedge clk);
        #2;
        chk(count == '0, "R1", int'(count), 0);
        up = 1'b0;
        #1;
        chk(tc_n == 1'b0, "R7", int'(tc_n), 0);
        up = 1'b1;
        rst_n = 1'b1;
        exp_cnt = '0;

        // R3: long up sequence through the 255 to 0 wrap
        for (int i = 0; i < 300; i++) cyc(1'b1, 2'b00, 1'b0, 1'b1, 8'h00, "R3");
        // R4: long down sequence through the 0 to 255 wrap
        for (int i = 0; i < 300; i++) cyc(1'b1, 2'b00, 1'b0, 1'b0, 8'h00, "R4");

        // R2: load in the middle of a count, with trickle disabled too
        for (int i = 0; i < 5; i++) cyc(1'b1, 2'b00, 1'b0, 1'b1, 8'h00, "R3");
        cyc(1'b0, 2'b00, 1'b0, 1'b1, 8'hA5, "R2");
        cyc(1'b0, 2'b11, 1'b1, 1'b0, 8'h3C, "R2");
        for (int i = 0; i < 4; i++) cyc(1'b1, 2'b00, 1'b0, 1'b1, 8'h00, "R3");

        // R5: hold stage 0 at 15; stage 1 still counts via the flag
        cyc(1'b0, 2'b00, 1'b0, 1'b1, 8'h3F, "R2");
        for (int i = 0; i < 3; i++) cyc(1'b1, 2'b01, 1'b0, 1'b1, 8'h00, "R5");
        // R5: stage 0 held at a non-terminal value: whole count holds
        cyc(1'b0, 2'b00, 1'b0, 1'b1, 8'h35, "R2");
        for (int i = 0; i < 3; i++) cyc(1'b1, 2'b01, 1'b0, 1'b1, 8'h00, "R5");
        // R5: hold stage 1 while stage 0 counts through its wrap
        for (int i = 0; i < 20; i++) cyc(1'b1, 2'b10, 1'b0, 1'b1, 8'h00, "R5");
        for (int i = 0; i < 20; i++) cyc(1'b1, 2'b10, 1'b0, 1'b0, 8'h00, "R5");

        // R6 and R7: trickle high at 255 holds and keeps the flag high
        cyc(1'b0, 2'b00, 1'b0, 1'b1, 8'hFF, "R2");
        cyc(1'b1, 2'b00, 1'b1, 1'b1, 8'h00, "R6");
        // R7: flag ignores the parallel enables
        cyc(1'b1, 2'b11, 1'b0, 1'b1, 8'h00, "R5");
        chk(tc_n == 1'b0, "R7", int'(tc_n), 0);

        // R8: flag follows direction and trickle with no clock edge
        up = 1'b0;
        #1;
        chk(tc_n == 1'b1, "R8", int'(tc_n), 1);
        up = 1'b1;
        #1;
        chk(tc_n == 1'b0, "R8", int'(tc_n), 0);
        trk_en_n = 1'b1;
        #1;
        chk(tc_n == 1'b1, "R8", int'(tc_n), 1);
        trk_en_n = 1'b0;
        #1;
        chk(tc_n == 1'b0, "R8", int'(tc_n), 0);

        // Sweep: every value loaded, then every enable/direction combination
        for (int v = 0; v < 256; v++) begin
            for (int m = 0; m < 16; m++) begin
                cyc(1'b0, 2'(m), m[2], m[3], 8'(v), "R2");
                if (m[2]) tag = "R6";
                else if (m[1:0] != 2'b00) tag = "R5";
                else if (m[3]) tag = "R3";
                else tag = "R4";
                cyc(1'b1, 2'(m), m[2], m[3], 8'(v ^ 8'h5A), tag);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule